// File: doc/BRIEF.md
# Paged SPI Touchscreen Register Slave

This block is a byte-oriented SPI slave that makes a touchscreen controller look like a paged file of 8-bit registers. A host opens a transaction by pulling chip select low and sending a command byte that names a starting register and a direction. Every byte after that is a data byte handled at the current register address. The address then advances by one, so a single transaction can write or read a run of consecutive registers.

Register 0 holds the active page number, and the page decides how reads are decoded. Reads do not return stored contents. They return values built from the sensor-side inputs. One page reports touch status. Another page reports the X and Y coordinates as high/low byte pairs, repeated over a range of addresses, so that one burst returns several samples. Every other read returns 0xFF. The coordinates are captured once per transaction, when the command byte completes, so all bytes of a burst agree with each other.

The bus inputs are sampled by the block clock `clk`. SCLK must stay high and low for at least three `clk` cycles each.

Top module: `tsc_paged_spi_slave`

## Requirements
- R1: The first complete byte after chip select falls is the command. Bits [7:1] give the register address. Bit 0 = 1 selects read mode and bit 0 = 0 selects write mode.
- R2: In write mode, each data byte is stored into the register at the current address. In read mode nothing is stored. After every data byte the address increases by one.
- R3: The bus uses SPI mode 0, MSB first. MOSI is sampled on SCLK rising edges and MISO changes after falling edges.
  - Each byte received yields one response byte, and that response is shifted out during the following frame.
  - The first frame of a transaction returns 0xFF.
  - MISO is held high while chip select is high.
- R4: There are 128 registers and all of them reset to 0x00. Register 0 is the page. Directly after reset (page 0), every read returns 0xFF.
- R5: On page 3:
  - Address 9 returns 0x00 while touch_present is 1 and 0x40 while it is 0.
  - Address 14 returns 0x00 while touch_present is 1 and 0x02 while it is 0.
- R6: On page 252, odd addresses 1 to 9 return the X high byte, {4'b0, X[11:8]}. Even addresses 2 to 10 return the X low byte, X[7:0].
- R7: On page 252, odd addresses 11 to 19 return the Y high byte, {4'b0, Y[11:8]}. Even addresses 12 to 20 return the Y low byte, Y[7:0].
- R8: A read on any page other than 3 or 252, or of any address not listed in R5 to R7, returns 0xFF.
- R9: X and Y are captured when the command byte completes. Coordinate reads later in that transaction use the captured values, even if the inputs change.
- R10: The address wraps from 127 to 0 on increment, for both reads and writes.
- R11: Raising chip select at any point makes the next byte a command byte again and discards any partly received byte.
- R12: The response to each byte is decoded at the address that byte used. For the command this is its own address. For a data byte it is the address before the increment. The decode uses the page held before that byte's write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to host |
| touch_present | input | 1 | High while the screen is touched |
| touch_x | input | 12 | X coordinate |
| touch_y | input | 12 | Y coordinate |

## Verification
A long burst read over the whole coordinate range tells X bytes from Y bytes and high bytes from low bytes. The X value changes partway through that burst, which separates capture at the command from live sampling.

Read bursts that start at address 127 show that the address wraps. Because register 0 is passed over in read mode with a zero MOSI byte, they also show that reads store nothing. A write burst that reaches register 0 only by wrapping confirms that writes advance the address.

The status page is read with touch_present both low and high, and an unknown page is also read. A transaction aborted after three bits shows that the command phase is restored and the partial byte is dropped.

// File: rtl/tsc_pkg.sv
// Package: shared constants, types and helpers for the paged touchscreen slave.
// Assumes 8-bit frames; the address width follows from the frame width.
package tsc_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int WIDE_W = 2 * BYTE_W;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Picks the high or low byte of a zero-extended coordinate.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WIDE_W-1:0] v, input logic hi);
        return hi ? v[WIDE_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/tsc_spi_shifter.sv
// Module: bit-level SPI mode 0 shifter.
// Samples MOSI on SCLK rising edges and pulses byte_valid once per full byte.
// Shifts MISO on falling edges inside a frame, and loads the response byte between frames.
// Assumes the SPI pins are synchronous to clk and each SCLK phase lasts at least 3 clk cycles.
module tsc_spi_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              rise, fall;

    assign rise = sclk && !sclk_q && !cs_n;
    assign fall = !sclk && sclk_q && !cs_n;
    assign miso = tx_sr[BYTE_W-1];

    // Receive path: count bits, assemble the byte, flag its completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else begin
            sclk_q     <= sclk;
            byte_valid <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sr <= {rx_sr[BYTE_W-3:0], mosi};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt    <= '0;
                    byte_valid <= 1'b1;
                    rx_byte    <= {rx_sr, mosi};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Transmit path: idle high, load the response, shift on falling edges within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '1;
        end else if (cs_n) begin
            tx_sr <= '1;
        end else if (load_en) begin
            tx_sr <= load_byte;
        end else if (fall && bit_cnt != '0) begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/tsc_reg_ctrl.sv
// Module: command state machine, address counter, register file and coordinate capture.
// Assumes byte_valid is a single-cycle pulse. Chip select high overrides everything.
module tsc_reg_ctrl
    import tsc_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic [COORD_W-1:0] touch_x,
    input  logic [COORD_W-1:0] touch_y,
    output logic               in_cmd,
    output logic               rd_mode,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [ADDR_W-1:0]  used_addr,
    output logic [BYTE_W-1:0]  page,
    output logic [COORD_W-1:0] x_lat,
    output logic [COORD_W-1:0] y_lat,
    output logic [COORD_W-1:0] x_src,
    output logic [COORD_W-1:0] y_src
);
    localparam int DEPTH = 1 << ADDR_W;

    phase_e            phase;
    logic [BYTE_W-1:0] regs [DEPTH];
    logic              take;
    logic              wr_en;

    assign in_cmd    = (phase == PH_CMD);
    assign take      = byte_valid && !cs_n;
    assign wr_en     = take && !in_cmd && !rd_mode;
    assign used_addr = in_cmd ? rx_byte[BYTE_W-1:1] : cur_addr;
    assign x_src     = in_cmd ? touch_x : x_lat;
    assign y_src     = in_cmd ? touch_y : y_lat;
    assign page      = regs[0];

    // Command/data sequencing, address advance and coordinate capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            rd_mode  <= 1'b1;
            cur_addr <= '0;
            x_lat    <= '0;
            y_lat    <= '0;
        end else if (cs_n) begin
            phase   <= PH_CMD;
            rd_mode <= 1'b1;
        end else if (take) begin
            if (in_cmd) begin
                phase    <= PH_DATA;
                cur_addr <= rx_byte[BYTE_W-1:1];
                rd_mode  <= rx_byte[0];
                x_lat    <= touch_x;
                y_lat    <= touch_y;
            end else begin
                cur_addr <= cur_addr + 1'b1;
            end
        end
    end

    // Register file: cleared on reset, written only by write-mode data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[cur_addr] <= rx_byte;
        end
    end
endmodule

// File: rtl/tsc_read_decode.sv
// Module: combinational read decode by page. The status page reports touch state.
// The coordinate page repeats X then Y as high/low pairs, SAMPLES times each. Everything else reads all ones.
module tsc_read_decode
    import tsc_pkg::*;
#(
    parameter int COORD_W     = 12,
    parameter int STATUS_PAGE = 3,
    parameter int COORD_PAGE  = 252,
    parameter int SAMPLES     = 5,
    parameter int STAT_A_ADDR = 9,
    parameter int STAT_A_IDLE = 8'h40,
    parameter int STAT_B_ADDR = 14,
    parameter int STAT_B_IDLE = 8'h02
) (
    input  logic [BYTE_W-1:0]  page,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               touched,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [BYTE_W-1:0]  rdata
);
    localparam int X_LAST = 2 * SAMPLES;
    localparam int Y_LAST = 4 * SAMPLES;

    logic [WIDE_W-1:0] x_wide, y_wide;
    int                a;

    assign x_wide = WIDE_W'(x);
    assign y_wide = WIDE_W'(y);
    assign a      = int'(addr);

    // Page-dependent read value.
    always_comb begin
        rdata = '1;
        if (page == BYTE_W'(STATUS_PAGE)) begin
            if (a == STAT_A_ADDR)      rdata = touched ? '0 : BYTE_W'(STAT_A_IDLE);
            else if (a == STAT_B_ADDR) rdata = touched ? '0 : BYTE_W'(STAT_B_IDLE);
        end else if (page == BYTE_W'(COORD_PAGE)) begin
            if (a >= 1 && a <= X_LAST)           rdata = pick_byte(x_wide, addr[0]);
            else if (a > X_LAST && a <= Y_LAST)  rdata = pick_byte(y_wide, addr[0]);
        end
    end
endmodule

// File: rtl/tsc_paged_spi_slave.sv
// Top: paged SPI touchscreen register slave.
// Ties the shifter, the control/register file and the read decode together.
// The response for a byte is decoded in the cycle that the byte completes, and loaded for the next frame.
module tsc_paged_spi_slave
    import tsc_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic               spi_miso,
    input  logic               touch_present,
    input  logic [COORD_W-1:0] touch_x,
    input  logic [COORD_W-1:0] touch_y
);
    logic               byte_valid;
    logic [BYTE_W-1:0]  rx_byte;
    logic               in_cmd, rd_mode;
    logic [ADDR_W-1:0]  cur_addr, used_addr;
    logic [BYTE_W-1:0]  page, rdata;
    logic [COORD_W-1:0] x_lat, y_lat, x_src, y_src;

    tsc_spi_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .load_en(byte_valid && !spi_cs_n), .load_byte(rdata),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .miso(spi_miso)
    );

    tsc_reg_ctrl #(.COORD_W(COORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .touch_x(touch_x), .touch_y(touch_y), .in_cmd(in_cmd), .rd_mode(rd_mode),
        .cur_addr(cur_addr), .used_addr(used_addr), .page(page),
        .x_lat(x_lat), .y_lat(y_lat), .x_src(x_src), .y_src(y_src)
    );

    tsc_read_decode #(.COORD_W(COORD_W)) u_dec (
        .page(page), .addr(used_addr), .touched(touch_present),
        .x(x_src), .y(y_src), .rdata(rdata)
    );
endmodule

// File: rtl/tsc_checker.sv
// Checker: temporal properties of the paged slave, attached by bind to the top module.
module tsc_checker #(
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 7,
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               miso,
    input logic               byte_valid,
    input logic [BYTE_W-1:0]  rx_byte,
    input logic               in_cmd,
    input logic               rd_mode,
    input logic [ADDR_W-1:0]  cur_addr,
    input logic [BYTE_W-1:0]  page,
    input logic [COORD_W-1:0] x_lat
);
    // R1: a command byte loads address and direction
    p_cmd_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !cs_n && in_cmd) |=>
            (cur_addr == $past(rx_byte[BYTE_W-1:1])) && (rd_mode == $past(rx_byte[0])));

    // R2: page changes only through a write-mode data byte
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && !cs_n && !in_cmd && !rd_mode) |=> $stable(page));

    // R3: MISO is high while deselected
    p_idle_miso_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> miso);

    // R9: captured X changes only at a command byte
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && !cs_n && in_cmd) |=> $stable(x_lat));

    // R10: data bytes advance the address with wrap
    p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !cs_n && !in_cmd) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

    // R11: release of chip select returns to command phase, read default
    p_release_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (in_cmd && rd_mode));
endmodule

bind tsc_paged_spi_slave tsc_checker #(.BYTE_W(8), .ADDR_W(7), .COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .miso(spi_miso), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .in_cmd(in_cmd), .rd_mode(rd_mode), .cur_addr(cur_addr),
    .page(page), .x_lat(x_lat)
);

// File: tb/tsc_paged_spi_slave_bench.sv
// Bench: drives SPI transactions and checks every returned byte against a behavioural model.
// Also checks that MISO idles high on every clock while deselected.
module tsc_paged_spi_slave_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        miso;
    logic        touch = 1'b0;
    logic [11:0] tx_in = 12'hABC, ty_in = 12'h123;

    int checks = 0, failures = 0;
    int cs_hi_cnt = 0;
    bit done = 0;

    // behavioural model state
    int mregs[128];
    int maddr = 0, mx = 0, my = 0, pending = 255;
    bit mrd = 1, mcmd = 1;

    always #2 clk = ~clk;

    tsc_paged_spi_slave u_tsc_paged_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .touch_present(touch), .touch_x(tx_in), .touch_y(ty_in)
    );

    function automatic int m_dec(int pg, int a, bit t, int x, int y);
        if (pg == 3) begin
            if (a == 9)  return t ? 0 : 8'h40;
            if (a == 14) return t ? 0 : 8'h02;
            return 255;
        end
        if (pg == 252) begin
            if (a >= 1 && a <= 10)  return (a % 2) ? (x >> 8) : (x & 255);
            if (a >= 11 && a <= 20) return (a % 2) ? (y >> 8) : (y & 255);
        end
        return 255;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // R3: MISO high while deselected, compared on every clock
    always @(negedge clk) begin
        if (rst_n && cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
        if (cs_hi_cnt >= 2 && !done) check("R3 idle", int'(miso), 1);
    end

    task automatic shift_bits(input logic [7:0] mo, input int n, output logic [7:0] got);
        got = 8'hFF;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = mo[i];
            repeat (HALF) @(negedge clk);
            got[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0; pending = 255; mcmd = 1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1; mrd = 1; mcmd = 1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // one full byte: compare the returned byte, then advance the model
    task automatic xfer(input logic [7:0] mo, input string tag);
        logic [7:0] got;
        shift_bits(mo, 8, got);
        check(tag, int'(got), pending);
        if (mcmd) begin
            maddr = int'(mo) >> 1; mrd = mo[0]; mcmd = 0;
            mx = int'(tx_in); my = int'(ty_in);
            pending = m_dec(mregs[0], maddr, touch, mx, my);
        end else begin
            pending = m_dec(mregs[0], maddr, touch, mx, my);
            if (!mrd) mregs[maddr] = int'(mo);
            maddr = (maddr + 1) % 128;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] junk;
        for (int i = 0; i < 128; i++) mregs[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 reset miso", int'(miso), 1);

        // R4 R8: page 0 after reset reads all ones
        cs_begin(); xfer(8'h03, "R4"); xfer(8'h00, "R4"); xfer(8'h00, "R8"); cs_end();

        // R1 R2: write page 252 into register 0
        cs_begin(); xfer(8'h00, "R1"); xfer(8'hFC, "R2"); cs_end();

        // R6 R7 R12 R9: full coordinate burst, X changed midway
        cs_begin(); xfer(8'h03, "R12");
        for (int i = 0; i < 21; i++) begin
            if (i == 4) tx_in = 12'h5A5;
            xfer(8'h00, (i < 10) ? "R6 R9" : "R7");
        end
        cs_end();
        // R9: new transaction sees the new X
        cs_begin(); xfer(8'h03, "R9"); xfer(8'h00, "R9"); xfer(8'h00, "R9"); cs_end();

        // R10 R2: read wraps through register 0 without storing
        cs_begin(); xfer(8'hFF, "R10");
        for (int i = 0; i < 4; i++) xfer(8'h00, "R10 R2");
        cs_end();

        // R5: status page, untouched then touched
        cs_begin(); xfer(8'h00, "R2"); xfer(8'h03, "R2"); cs_end();
        for (int t = 0; t < 2; t++) begin
            touch = t[0];
            cs_begin(); xfer(8'h13, "R5");
            for (int i = 0; i < 7; i++) xfer(8'h00, "R5 R8");
            cs_end();
        end

        // R8: unknown page
        cs_begin(); xfer(8'h00, "R2"); xfer(8'h07, "R2"); cs_end();
        cs_begin(); xfer(8'h03, "R8"); xfer(8'h00, "R8"); xfer(8'h00, "R8"); cs_end();

        // R10 R2: write burst reaching register 0 by wrap
        cs_begin(); xfer(8'hFE, "R10"); xfer(8'h55, "R10"); xfer(8'hFC, "R10"); cs_end();

        // R11: aborted partial byte, then a clean read
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        shift_bits(8'hA5, 3, junk);
        cs_end();
        ty_in = 12'hFED;
        cs_begin(); xfer(8'h17, "R11");
        for (int i = 0; i < 4; i++) xfer(8'h00, "R11 R7");
        cs_end();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule